// File: doc/BRIEF.md
# PCI Configuration Address/Data Port

This block is the host-facing configuration access path of a PCI bridge. Software first writes a 32-bit target address word: enable flag, bus, device, function and dword register. It then reads or writes a data window. Each enabled data access turns into one configuration request on an abstract downstream request/response interface. The CPU-side access stalls until that request has been answered.

A small command register sits next to the address word. Its bit 0 selects whether configuration data is byte-reversed. Reversal only ever applies to targets other than the bridge itself, that is anything but bus 0, device 0. While the enable flag is clear, the data window is inert. Reads of it give all ones, and writes to it disappear, with no downstream traffic in either case.

Top module: `cfg_port`

## Requirements
- R1: After reset the address word reads 0x00000000 and the command register reads 0x00010001 (parameter `BOOT_LITTLE`=1; it reads 0 when `BOOT_LITTLE`=0).
- R2: A write to the address word (select code 1) stores the data ANDed with 0x80fffffc, and reading select code 1 returns the stored value.
- R3: A write to the command register (select code 0) stores the data ANDed with 0x0401fc0f, and reading select code 0 returns the stored value. The register changes on no other access.
- R4: With address bit 31 clear, a read of the data window (select code 2) completes in one cycle, returns 0xffffffff and issues no downstream request.
- R5: With address bit 31 clear, a write of the data window completes in one cycle and issues no downstream request.
- R6: With address bit 31 set, a data access raises `cfg_req_valid` with the write flag, the bus from address bits [23:16], the device from [15:11], the function from [10:8] and the dword register from [7:2]. It also carries the (possibly swapped) write data. All of these stay stable until `cfg_req_ready` is seen.
- R7: An enabled data access completes (`cpu_done` for exactly one cycle) in the cycle after the response is taken. `cfg_rsp_valid` is only legal after the request handshake. The access takes 3 + (ready wait cycles) + (response wait cycles) cycles from issue to done.
- R8: When command bit 0 is 0 and address bits [23:11] are nonzero, the data is byte-reversed (byte 0 swapped with byte 3, byte 1 with byte 2). This applies to write data sent downstream and to read data returned to the CPU.
- R9: When command bit 0 is 1, or when address bits [23:11] are all zero, data passes unchanged in both directions.
- R10: Select code 3 is reserved: reads return 0, writes complete in one cycle and change neither the address word nor the command register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_sel | input | 1 | CPU access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_reg | input | 2 | Select: 0 command, 1 address word, 2 data window, 3 reserved |
| cpu_wdata | input | 32 | CPU write data |
| cpu_done | output | 1 | One-cycle completion strobe |
| cpu_rdata | output | 32 | Read data, valid while `cpu_done` is high |
| cfg_req_valid | output | 1 | Downstream configuration request valid |
| cfg_req_ready | input | 1 | Downstream accepts the request |
| cfg_req_write | output | 1 | 1 = configuration write |
| cfg_req_bus | output | 8 | Target bus number |
| cfg_req_dev | output | 5 | Target device number |
| cfg_req_func | output | 3 | Target function number |
| cfg_req_reg | output | 6 | Target dword register index |
| cfg_req_wdata | output | 32 | Configuration write data |
| cfg_rsp_valid | input | 1 | Downstream response valid |
| cfg_rsp_rdata | input | 32 | Downstream response data |

## Verification
The request handshake and the response can fall in back-to-back cycles: the request can be presented and accepted in one cycle, and the response can then be taken on the very next edge. The byte-reversal decision must hold over both of those events. The bench runs the same enabled reads and writes with zero-wait and with delayed ready and response. The scoreboard compares each request against the queued expectation at its handshake, and the completion latency is checked against 3 plus the inserted waits. The bench also provokes the case where a reversed read response arrives immediately after acceptance. It judges that case by the reversed word reaching the CPU.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  localparam int CFG_DW    = 32;
  localparam int CFG_BYTES = CFG_DW / 8;
  localparam int BUS_W     = 8;
  localparam int DEV_W     = 5;
  localparam int FUNC_W    = 3;
  localparam int DREG_W    = 6;

  localparam logic [CFG_DW-1:0] ADDR_KEEP  = 32'h80ff_fffc;
  localparam logic [CFG_DW-1:0] CMD_KEEP   = 32'h0401_fc0f;
  localparam logic [CFG_DW-1:0] CMD_BOOT_L = 32'h0001_0001;
  localparam logic [CFG_DW-1:0] FLOAT_WORD = 32'hffff_ffff;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_RSV  = 2'd3
  } sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

endpackage

// File: rtl/cfg_port_swap.sv
module cfg_port_swap #(
  parameter int BYTES = 4
) (
  input  logic [BYTES*8-1:0] din,
  output logic [BYTES*8-1:0] dout
);
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign dout[b*8 +: 8] = din[(BYTES-1-b)*8 +: 8];
  end
endmodule

// File: rtl/cfg_port_regs.sv
module cfg_port_regs
  import cfg_port_pkg::*;
#(
  parameter bit BOOT_LITTLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr,
  input  logic              wr_cmd,
  input  logic [CFG_DW-1:0] wdata,
  output logic [CFG_DW-1:0] addr_q,
  output logic [CFG_DW-1:0] cmd_q,
  output logic              cfg_en,
  output logic              swap_en,
  output logic [BUS_W-1:0]  f_bus,
  output logic [DEV_W-1:0]  f_dev,
  output logic [FUNC_W-1:0] f_func,
  output logic [DREG_W-1:0] f_reg
);
  localparam logic [CFG_DW-1:0] CMD_RST = BOOT_LITTLE ? CMD_BOOT_L : '0;
  localparam int TGT_LO = 11;
  localparam int TGT_HI = 23;

  logic [CFG_DW-1:0] addr_d, cmd_d;

  always_comb begin
    addr_d = addr_q;
    cmd_d  = cmd_q;
    if (wr_addr) addr_d = wdata & ADDR_KEEP;
    if (wr_cmd)  cmd_d  = wdata & CMD_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmd_q  <= CMD_RST;
    end else begin
      if (wr_addr) addr_q <= addr_d;
      if (wr_cmd)  cmd_q  <= cmd_d;
    end
  end

  assign cfg_en  = addr_q[CFG_DW-1];
  assign swap_en = !cmd_q[0] && (|addr_q[TGT_HI:TGT_LO]);
  assign f_bus   = addr_q[23:16];
  assign f_dev   = addr_q[15:11];
  assign f_func  = addr_q[10:8];
  assign f_reg   = addr_q[7:2];

  a_r3_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmd |=> $stable(cmd_q));
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_addr |=> $stable(addr_q));
endmodule

// File: rtl/cfg_port_seq.sv
module cfg_port_seq
  import cfg_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_reg,
  input  logic [CFG_DW-1:0] cpu_wdata,
  input  logic [CFG_DW-1:0] cpu_wdata_sw,
  output logic              cpu_done,
  output logic [CFG_DW-1:0] cpu_rdata,
  input  logic [CFG_DW-1:0] addr_q,
  input  logic [CFG_DW-1:0] cmd_q,
  input  logic              cfg_en,
  input  logic              swap_en,
  output logic              wr_addr,
  output logic              wr_cmd,
  output logic              cfg_req_valid,
  input  logic              cfg_req_ready,
  output logic              cfg_req_write,
  output logic [CFG_DW-1:0] cfg_req_wdata,
  input  logic              cfg_rsp_valid,
  input  logic [CFG_DW-1:0] cfg_rsp_rdata,
  input  logic [CFG_DW-1:0] cfg_rsp_rdata_sw
);
  seq_state_e        state_q, state_d;
  logic [CFG_DW-1:0] rdata_q, rdata_d;
  logic              rdata_ld;
  logic              wr_q;
  logic [CFG_DW-1:0] wdata_q, wdata_d;
  logic              accept;
  sel_e              sel;

  assign sel    = sel_e'(cpu_reg);
  assign accept = (state_q == ST_IDLE) && cpu_sel;

  always_comb begin
    state_d  = state_q;
    rdata_d  = rdata_q;
    rdata_ld = 1'b0;
    wr_addr  = 1'b0;
    wr_cmd   = 1'b0;
    wdata_d  = swap_en ? cpu_wdata_sw : cpu_wdata;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_sel) begin
          rdata_ld = 1'b1;
          state_d  = ST_DONE;
          unique case (sel)
            SEL_CMD: begin
              rdata_d = cmd_q;
              wr_cmd  = cpu_we;
            end
            SEL_ADDR: begin
              rdata_d = addr_q;
              wr_addr = cpu_we;
            end
            SEL_DATA: begin
              rdata_d = FLOAT_WORD;
              if (cfg_en) state_d = ST_REQ;
            end
            default: rdata_d = '0;
          endcase
        end
      end
      ST_REQ: begin
        if (cfg_req_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (cfg_rsp_valid) begin
          rdata_ld = 1'b1;
          rdata_d  = swap_en ? cfg_rsp_rdata_sw : cfg_rsp_rdata;
          state_d  = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rdata_q <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (rdata_ld) rdata_q <= rdata_d;
      if (accept) begin
        wr_q    <= cpu_we;
        wdata_q <= wdata_d;
      end
    end
  end

  assign cpu_done      = (state_q == ST_DONE);
  assign cpu_rdata     = rdata_q;
  assign cfg_req_valid = (state_q == ST_REQ);
  assign cfg_req_write = wr_q;
  assign cfg_req_wdata = wdata_q;

  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && !cfg_req_ready |=>
      cfg_req_valid && $stable(cfg_req_write) && $stable(cfg_req_wdata));
  a_r4_req_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> cfg_en);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
  a_r7_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rsp_valid |-> state_q == ST_WAIT);
  a_r5_no_req_off: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !cfg_en |=> !cfg_req_valid);
endmodule

// File: rtl/cfg_port.sv
module cfg_port
  import cfg_port_pkg::*;
#(
  parameter bit BOOT_LITTLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_reg,
  input  logic [CFG_DW-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [CFG_DW-1:0] cpu_rdata,
  output logic              cfg_req_valid,
  input  logic              cfg_req_ready,
  output logic              cfg_req_write,
  output logic [BUS_W-1:0]  cfg_req_bus,
  output logic [DEV_W-1:0]  cfg_req_dev,
  output logic [FUNC_W-1:0] cfg_req_func,
  output logic [DREG_W-1:0] cfg_req_reg,
  output logic [CFG_DW-1:0] cfg_req_wdata,
  input  logic              cfg_rsp_valid,
  input  logic [CFG_DW-1:0] cfg_rsp_rdata
);
  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic [CFG_DW-1:0] addr_q, cmd_q, wdata_sw, rsp_sw;
  logic              cfg_en, swap_en, wr_addr, wr_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  cfg_port_swap #(.BYTES(CFG_BYTES)) u_swap_wr (.din(cpu_wdata),     .dout(wdata_sw));
  cfg_port_swap #(.BYTES(CFG_BYTES)) u_swap_rd (.din(cfg_rsp_rdata), .dout(rsp_sw));

  cfg_port_regs #(.BOOT_LITTLE(BOOT_LITTLE)) u_regs (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_addr (wr_addr),
    .wr_cmd  (wr_cmd),
    .wdata   (cpu_wdata),
    .addr_q  (addr_q),
    .cmd_q   (cmd_q),
    .cfg_en  (cfg_en),
    .swap_en (swap_en),
    .f_bus   (cfg_req_bus),
    .f_dev   (cfg_req_dev),
    .f_func  (cfg_req_func),
    .f_reg   (cfg_req_reg)
  );

  cfg_port_seq u_seq (
    .clk              (clk),
    .rst_n            (rst_core_n),
    .cpu_sel          (cpu_sel),
    .cpu_we           (cpu_we),
    .cpu_reg          (cpu_reg),
    .cpu_wdata        (cpu_wdata),
    .cpu_wdata_sw     (wdata_sw),
    .cpu_done         (cpu_done),
    .cpu_rdata        (cpu_rdata),
    .addr_q           (addr_q),
    .cmd_q            (cmd_q),
    .cfg_en           (cfg_en),
    .swap_en          (swap_en),
    .wr_addr          (wr_addr),
    .wr_cmd           (wr_cmd),
    .cfg_req_valid    (cfg_req_valid),
    .cfg_req_ready    (cfg_req_ready),
    .cfg_req_write    (cfg_req_write),
    .cfg_req_wdata    (cfg_req_wdata),
    .cfg_rsp_valid    (cfg_rsp_valid),
    .cfg_rsp_rdata    (cfg_rsp_rdata),
    .cfg_rsp_rdata_sw (rsp_sw)
  );

  a_r6_fields_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    cfg_req_valid && !cfg_req_ready |=>
      $stable(cfg_req_bus) && $stable(cfg_req_dev) &&
      $stable(cfg_req_func) && $stable(cfg_req_reg));
endmodule

// File: tb/cfg_port_bench.sv
module cfg_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_sel = 1'b0, cpu_we = 1'b0;
  logic [1:0]  cpu_reg = 2'd0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_done;
  logic [31:0] cpu_rdata;
  logic        cfg_req_valid, cfg_req_write;
  logic        cfg_req_ready = 1'b0;
  logic [7:0]  cfg_req_bus;
  logic [4:0]  cfg_req_dev;
  logic [2:0]  cfg_req_func;
  logic [5:0]  cfg_req_reg;
  logic [31:0] cfg_req_wdata;
  logic        cfg_rsp_valid = 1'b0;
  logic [31:0] cfg_rsp_rdata = '0;

  always #2.5 clk = ~clk;

  cfg_port u_cfg_port (.*);

  typedef struct packed {
    logic        wr;
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [5:0]  rg;
    logic [31:0] wd;
  } exp_t;

  exp_t        exp_q[$];
  int          n_run = 0, n_fail = 0, n_req = 0;
  int          ready_dly = 0, rsp_dly = 0;
  logic [31:0] rsp_word = '0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // downstream responder and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (cfg_req_valid) begin
        repeat (ready_dly) @(negedge clk);
        n_req++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R4/R5 unexpected request", {31'd0, cfg_req_write}, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(cfg_req_write == e.wr, "R6 write flag", {31'd0, cfg_req_write}, {31'd0, e.wr});
          check({cfg_req_bus, cfg_req_dev, cfg_req_func, cfg_req_reg} ==
                {e.bus, e.dev, e.fn, e.rg}, "R6 fields",
                {10'd0, cfg_req_bus, cfg_req_dev, cfg_req_func, cfg_req_reg},
                {10'd0, e.bus, e.dev, e.fn, e.rg});
          if (e.wr)
            check(cfg_req_wdata == e.wd, "R8/R9 downstream wdata", cfg_req_wdata, e.wd);
        end
        cfg_req_ready = 1'b1;
        @(negedge clk);
        cfg_req_ready = 1'b0;
        repeat (rsp_dly) @(negedge clk);
        cfg_rsp_valid = 1'b1;
        cfg_rsp_rdata = rsp_word;
        @(negedge clk);
        cfg_rsp_valid = 1'b0;
      end
    end
  end

  task automatic acc(input logic we, input logic [1:0] r, input logic [31:0] wd,
                     output logic [31:0] rd, output int lat);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = we; cpu_reg = r; cpu_wdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!cpu_done);
    rd = cpu_rdata;
    cpu_sel = 1'b0;
  endtask

  task automatic push(input logic wr, input logic [31:0] a, input logic [31:0] wd);
    exp_t e;
    e.wr = wr; e.bus = a[23:16]; e.dev = a[15:11]; e.fn = a[10:8];
    e.rg = a[7:2]; e.wd = wd;
    exp_q.push_back(e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog all-requirements actual=expired expected=finished");
    summary();
  end

  initial begin
    logic [31:0] rd;
    int          lat, req0;
    logic [31:0] a1, a2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    acc(1'b0, 2'd1, '0, rd, lat);
    check(rd == 32'h0, "R1 addr reset", rd, 32'h0);
    acc(1'b0, 2'd0, '0, rd, lat);
    check(rd == 32'h0001_0001, "R1 cmd reset", rd, 32'h0001_0001);

    // R4 disabled read, R5 disabled write
    req0 = n_req;
    acc(1'b0, 2'd2, '0, rd, lat);
    check(rd == 32'hffff_ffff, "R4 disabled read value", rd, 32'hffff_ffff);
    check(lat == 1, "R4 disabled read latency", lat, 1);
    acc(1'b1, 2'd2, 32'h1234_5678, rd, lat);
    check(lat == 1, "R5 disabled write latency", lat, 1);
    repeat (4) @(negedge clk);
    check(n_req == req0, "R4 R5 no downstream request", n_req, req0);

    // R10 reserved select
    acc(1'b1, 2'd3, 32'hdead_beef, rd, lat);
    acc(1'b0, 2'd3, '0, rd, lat);
    check(rd == 32'h0, "R10 reserved read", rd, 32'h0);
    acc(1'b0, 2'd1, '0, rd, lat);
    check(rd == 32'h0, "R10 addr untouched", rd, 32'h0);
    acc(1'b0, 2'd0, '0, rd, lat);
    check(rd == 32'h0001_0001, "R10 cmd untouched", rd, 32'h0001_0001);

    // R2 / R3 write masks
    acc(1'b1, 2'd1, 32'hffff_ffff, rd, lat);
    acc(1'b0, 2'd1, '0, rd, lat);
    check(rd == 32'h80ff_fffc, "R2 addr mask", rd, 32'h80ff_fffc);
    acc(1'b1, 2'd0, 32'hffff_ffff, rd, lat);
    acc(1'b0, 2'd0, '0, rd, lat);
    check(rd == 32'h0401_fc0f, "R3 cmd mask", rd, 32'h0401_fc0f);

    // R6 R7 R9: cmd bit0 set, non-bridge target, no swap
    a1 = 32'h8012_2b2c;
    acc(1'b1, 2'd1, a1, rd, lat);
    ready_dly = 0; rsp_dly = 0;
    push(1'b1, a1, 32'h1122_3344);
    acc(1'b1, 2'd2, 32'h1122_3344, rd, lat);
    check(lat == 3, "R7 zero-wait write latency", lat, 3);
    ready_dly = 3; rsp_dly = 2; rsp_word = 32'ha1b2_c3d4;
    push(1'b0, a1, '0);
    acc(1'b0, 2'd2, '0, rd, lat);
    check(lat == 8, "R7 stalled read latency", lat, 8);
    check(rd == 32'ha1b2_c3d4, "R9 no swap when cmd bit0 set", rd, 32'ha1b2_c3d4);

    // R8 swap: cmd bit0 clear, non-bridge target
    acc(1'b1, 2'd0, 32'h0, rd, lat);
    ready_dly = 0; rsp_dly = 0;
    push(1'b1, a1, 32'h4433_2211);
    acc(1'b1, 2'd2, 32'h1122_3344, rd, lat);
    check(lat == 3, "R7 R8 swapped write latency", lat, 3);
    push(1'b0, a1, '0);
    acc(1'b0, 2'd2, '0, rd, lat);
    check(rd == 32'hd4c3_b2a1, "R8 read swap zero-wait", rd, 32'hd4c3_b2a1);
    ready_dly = 1; rsp_dly = 1; rsp_word = 32'h0102_0304;
    push(1'b0, a1, '0);
    acc(1'b0, 2'd2, '0, rd, lat);
    check(rd == 32'h0403_0201, "R8 read swap delayed", rd, 32'h0403_0201);
    check(lat == 5, "R7 delayed latency", lat, 5);

    // R9: bridge itself (bus0 dev0), cmd bit0 clear, no swap
    a2 = 32'h8000_0204;
    acc(1'b1, 2'd1, a2, rd, lat);
    ready_dly = 0; rsp_dly = 0; rsp_word = 32'hcafe_0011;
    push(1'b1, a2, 32'h5566_7788);
    acc(1'b1, 2'd2, 32'h5566_7788, rd, lat);
    push(1'b0, a2, '0);
    acc(1'b0, 2'd2, '0, rd, lat);
    check(rd == 32'hcafe_0011, "R9 bridge target no swap", rd, 32'hcafe_0011);

    // R4 again after clearing enable
    req0 = n_req;
    acc(1'b1, 2'd1, 32'h0012_2b2c, rd, lat);
    acc(1'b0, 2'd2, '0, rd, lat);
    check(rd == 32'hffff_ffff, "R4 read after disable", rd, 32'hffff_ffff);
    repeat (4) @(negedge clk);
    check(n_req == req0, "R4 no request after disable", n_req, req0);
    check(exp_q.size() == 0, "R6 all expected requests seen", exp_q.size(), 0);

    summary();
  end
endmodule